// File: doc/BRIEF.md
# Rule Firing Strength Unit

This block turns a set of membership degrees into the firing strength of one fuzzy rule, one rule per clock. Each antecedent contributes an unsigned degree of truth; a per-antecedent enable says which antecedents the rule actually uses. A masking stage first replaces each unused degree with full truth, so that it drops out of a minimum. When the rule uses no antecedent at all, every degree is forced to zero instead, so the rule contributes nothing.

The masked degrees are then combined by a connective chosen at run time by a 2-bit select: minimum, scaled product, maximum, or probabilistic OR. The products are rescaled to the degree width by keeping the upper half of each double-width product. The combination is applied pairwise, starting from antecedent 0 and folding in antecedents 1, 2 and so on in order. The result and a valid flag leave through a register pipeline of fixed, parameterized depth.

Top module: `fire_strength_unit`

## Requirements
- R1: With select 00 (minimum), the strength equals the smallest masked degree.
- R2: With select 01 (product), the strength is a left fold from antecedent 0 upward of acc = floor(acc*d / 2^DEG_W), starting with acc equal to the masked degree 0.
- R3: With select 10 (maximum), the strength equals the largest masked degree.
- R4: With select 11 (probabilistic OR), the strength is a left fold from antecedent 0 upward of acc = acc + d - floor(acc*d / 2^DEG_W), clipped to the all-ones value 2^DEG_W-1 (255 at the default width).
- R5: When at least one enable bit is set, each antecedent whose enable bit is 0 is treated as degree 2^DEG_W-1, whatever value its input field carries. Degree i occupies bits [i*DEG_W +: DEG_W] of the degree vector and is gated by enable bit i.
- R6: When every enable bit is 0, all masked degrees are 0, so the strength is 0 under every select value.
- R7: The strength and the valid flag for an input sampled at a rising edge appear LATENCY rising edges later; the valid flag out equals the valid flag in delayed by exactly LATENCY cycles.
- R8: While reset is high, and at the first edge after it falls, the valid flag out is 0 and the strength is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the current inputs as a rule to evaluate |
| degrees | input | NUM_ANT*DEG_W | Packed membership degrees, antecedent i in bits [i*DEG_W +: DEG_W] |
| ant_en | input | NUM_ANT | Antecedent enable, bit i gates degree i |
| norm_sel | input | 2 | Connective: 00 min, 01 product, 10 max, 11 probabilistic OR |
| out_valid | output | 1 | Valid flag, delayed by LATENCY cycles |
| strength | output | DEG_W | Registered rule firing strength |

## Verification
The bench builds the block with four antecedents of 8 bits and a two-stage output pipeline, so that the latency check sees data and the valid flag pass through more than one register and an invalid beat between valid ones is tracked. Eight-bit degrees put the saturation of the probabilistic OR at 255 and the truncation drift of repeated products (255 folded four times giving 252) within reach of directed cases. Four antecedents make the fold order and partial masks with several disabled positions visible, alongside the all-disabled rule under each connective.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        NORM_MIN  = 2'd0,
        NORM_PROD = 2'd1,
        NORM_MAX  = 2'd2,
        NORM_PSUM = 2'd3
    } norm_sel_e;

    localparam int DEF_NUM_ANT = 4;
    localparam int DEF_DEG_W   = 8;
    localparam int DEF_LATENCY = 1;

endpackage

// File: rtl/fsu_ant_mask.sv
module fsu_ant_mask #(
    parameter int NUM_ANT = 4,
    parameter int DEG_W   = 8
) (
    input  logic [NUM_ANT*DEG_W-1:0] deg_in,
    input  logic [NUM_ANT-1:0]       en,
    output logic [NUM_ANT*DEG_W-1:0] deg_out
);
    logic all_off;

    assign all_off = ~|en;

    // Unused antecedents become full truth; an empty rule becomes all zero.
    for (genvar i = 0; i < NUM_ANT; i++) begin : g_ant
        always_comb begin
            if (all_off)
                deg_out[i*DEG_W +: DEG_W] = '0;
            else if (en[i])
                deg_out[i*DEG_W +: DEG_W] = deg_in[i*DEG_W +: DEG_W];
            else
                deg_out[i*DEG_W +: DEG_W] = '1;
        end
    end
endmodule

// File: rtl/fsu_norm_pair.sv
module fsu_norm_pair
    import fsu_pkg::*;
#(
    parameter int DEG_W = 8
) (
    input  logic [DEG_W-1:0] a,
    input  logic [DEG_W-1:0] b,
    input  norm_sel_e        sel,
    output logic [DEG_W-1:0] y
);
    localparam int PROD_W = 2 * DEG_W;

    logic [PROD_W-1:0] prod;
    logic [DEG_W-1:0]  prod_hi;
    logic [DEG_W:0]    sum;
    logic [DEG_W:0]    psum;

    assign prod    = PROD_W'(a) * PROD_W'(b);
    assign prod_hi = prod[PROD_W-1:DEG_W];
    assign sum     = {1'b0, a} + {1'b0, b};
    assign psum    = sum - {1'b0, prod_hi};

    always_comb begin
        unique case (sel)
            NORM_MIN:  y = (a < b) ? a : b;
            NORM_PROD: y = prod_hi;
            NORM_MAX:  y = (a > b) ? a : b;
            NORM_PSUM: y = psum[DEG_W] ? {DEG_W{1'b1}} : psum[DEG_W-1:0];
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/fsu_norm_reduce.sv
module fsu_norm_reduce
    import fsu_pkg::*;
#(
    parameter int NUM_ANT = 4,
    parameter int DEG_W   = 8
) (
    input  logic [NUM_ANT*DEG_W-1:0] deg,
    input  norm_sel_e                sel,
    output logic [DEG_W-1:0]         result
);
    logic [DEG_W-1:0] acc [NUM_ANT];

    assign acc[0] = deg[DEG_W-1:0];

    // Left fold: antecedent 0 seeds the chain, higher indices join in order.
    for (genvar i = 1; i < NUM_ANT; i++) begin : g_fold
        fsu_norm_pair #(.DEG_W(DEG_W)) pair_i (
            .a   (acc[i-1]),
            .b   (deg[i*DEG_W +: DEG_W]),
            .sel (sel),
            .y   (acc[i])
        );
    end

    assign result = acc[NUM_ANT-1];
endmodule

// File: rtl/fsu_out_pipe.sv
module fsu_out_pipe #(
    parameter int DEG_W   = 8,
    parameter int LATENCY = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             v_in,
    input  logic [DEG_W-1:0] d_in,
    output logic             v_out,
    output logic [DEG_W-1:0] d_out
);
    typedef struct packed {
        logic             vld;
        logic [DEG_W-1:0] val;
    } stage_t;

    stage_t st [LATENCY];

    always_ff @(posedge clk) begin
        if (rst) st[0] <= '0;
        else     st[0] <= '{vld: v_in, val: d_in};
    end

    for (genvar k = 1; k < LATENCY; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) st[k] <= '0;
            else     st[k] <= st[k-1];
        end
    end

    assign v_out = st[LATENCY-1].vld;
    assign d_out = st[LATENCY-1].val;
endmodule

// File: rtl/fire_strength_unit.sv
module fire_strength_unit
    import fsu_pkg::*;
#(
    parameter int NUM_ANT = DEF_NUM_ANT,
    parameter int DEG_W   = DEF_DEG_W,
    parameter int LATENCY = DEF_LATENCY
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [NUM_ANT*DEG_W-1:0] degrees,
    input  logic [NUM_ANT-1:0]       ant_en,
    input  logic [SEL_W-1:0]         norm_sel,
    output logic                     out_valid,
    output logic [DEG_W-1:0]         strength
);
    logic [NUM_ANT*DEG_W-1:0] masked;
    logic [DEG_W-1:0]         comb_strength;
    norm_sel_e                sel_e;

    assign sel_e = norm_sel_e'(norm_sel);

    fsu_ant_mask #(.NUM_ANT(NUM_ANT), .DEG_W(DEG_W)) mask_i (
        .deg_in  (degrees),
        .en      (ant_en),
        .deg_out (masked)
    );

    fsu_norm_reduce #(.NUM_ANT(NUM_ANT), .DEG_W(DEG_W)) reduce_i (
        .deg    (masked),
        .sel    (sel_e),
        .result (comb_strength)
    );

    fsu_out_pipe #(.DEG_W(DEG_W), .LATENCY(LATENCY)) pipe_i (
        .clk   (clk),
        .rst   (rst),
        .v_in  (in_valid),
        .d_in  (comb_strength),
        .v_out (out_valid),
        .d_out (strength)
    );
endmodule

// File: rtl/fsu_checker.sv
module fsu_checker #(
    parameter int NUM_ANT = 4,
    parameter int DEG_W   = 8,
    parameter int LATENCY = 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic [NUM_ANT*DEG_W-1:0] degrees,
    input logic [NUM_ANT-1:0]       ant_en,
    input logic [1:0]               norm_sel,
    input logic                     out_valid,
    input logic [DEG_W-1:0]         strength
);
    localparam int LAST = LATENCY - 1;

    logic             v_q   [LATENCY];
    logic             off_q [LATENCY];
    logic             en0_q [LATENCY];
    logic [DEG_W-1:0] d0_q  [LATENCY];
    logic [1:0]       sel_q [LATENCY];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LATENCY; k++) begin
                v_q[k] <= 1'b0; off_q[k] <= 1'b0; en0_q[k] <= 1'b0;
                d0_q[k] <= '0;  sel_q[k] <= '0;
            end
        end else begin
            v_q[0]   <= in_valid;
            off_q[0] <= (ant_en == '0);
            en0_q[0] <= ant_en[0];
            d0_q[0]  <= degrees[DEG_W-1:0];
            sel_q[0] <= norm_sel;
            for (int k = 1; k < LATENCY; k++) begin
                v_q[k] <= v_q[k-1]; off_q[k] <= off_q[k-1]; en0_q[k] <= en0_q[k-1];
                d0_q[k] <= d0_q[k-1]; sel_q[k] <= sel_q[k-1];
            end
        end
    end

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && strength == '0));

    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid == v_q[LAST]);

    assert_empty_rule_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (v_q[LAST] && off_q[LAST]) |-> strength == '0);

    assert_min_bound_R1: assert property (@(posedge clk) disable iff (rst)
        (v_q[LAST] && en0_q[LAST] && sel_q[LAST] == 2'd0) |-> strength <= d0_q[LAST]);

    assert_prod_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (v_q[LAST] && en0_q[LAST] && sel_q[LAST] == 2'd1) |-> strength <= d0_q[LAST]);

    assert_max_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (v_q[LAST] && en0_q[LAST] && sel_q[LAST] == 2'd2) |-> strength >= d0_q[LAST]);

    assert_psum_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (v_q[LAST] && en0_q[LAST] && sel_q[LAST] == 2'd3) |-> strength >= d0_q[LAST]);
endmodule

bind fire_strength_unit fsu_checker #(
    .NUM_ANT(NUM_ANT), .DEG_W(DEG_W), .LATENCY(LATENCY)
) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .degrees(degrees),
    .ant_en(ant_en), .norm_sel(norm_sel), .out_valid(out_valid), .strength(strength)
);

// File: tb/fire_strength_unit_tb_top.sv
module fire_strength_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 4;
    localparam int W    = 8;
    localparam int LAT  = 2;
    localparam int MAXV = (1 << W) - 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [N*W-1:0] degrees = '0;
    logic [N-1:0]   ant_en = '0;
    logic [1:0]     norm_sel = '0;
    logic           out_valid;
    logic [W-1:0]   strength;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic         hv [LAT];
    logic [W-1:0] hd [LAT];
    string        ht [LAT];

    always #(CLK_PERIOD/2) clk = ~clk;

    fire_strength_unit #(.NUM_ANT(N), .DEG_W(W), .LATENCY(LAT)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .degrees(degrees),
        .ant_en(ant_en), .norm_sel(norm_sel), .out_valid(out_valid), .strength(strength)
    );

    function automatic int model(input logic [N*W-1:0] dg, input logic [N-1:0] en,
                                 input logic [1:0] sel);
        int e [N];
        int acc, t;
        for (int i = 0; i < N; i++)
            e[i] = (en == '0) ? 0 : (en[i] ? int'(dg[i*W +: W]) : MAXV);
        acc = e[0];
        for (int i = 1; i < N; i++) begin
            case (sel)
                2'd0: acc = (e[i] < acc) ? e[i] : acc;
                2'd1: acc = (acc * e[i]) >> W;
                2'd2: acc = (e[i] > acc) ? e[i] : acc;
                default: begin
                    t = acc + e[i] - ((acc * e[i]) >> W);
                    acc = (t > MAXV) ? MAXV : t;
                end
            endcase
        end
        return acc;
    endfunction

    function automatic string tag_of(input logic [N-1:0] en, input logic [1:0] sel);
        if (en == '0) return "R6";
        if (en != '1) return "R5";
        case (sel)
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Compare the oldest expectation, then drive new inputs (at negedge).
    task automatic step(input logic [N*W-1:0] dg, input logic [N-1:0] en,
                        input logic [1:0] sel, input logic vld);
        @(negedge clk);
        check("R7 valid", int'(out_valid), int'(hv[LAT-1]));
        if (hv[LAT-1]) check(ht[LAT-1], int'(strength), int'(hd[LAT-1]));
        for (int k = LAT-1; k > 0; k--) begin
            hv[k] = hv[k-1]; hd[k] = hd[k-1]; ht[k] = ht[k-1];
        end
        hv[0] = vld; hd[0] = W'(model(dg, en, sel)); ht[0] = tag_of(en, sel);
        degrees = dg; ant_en = en; norm_sel = sel; in_valid = vld;
    endtask

    function automatic logic [N*W-1:0] pack4(input int a, input int b, input int c, input int d);
        return {W'(d), W'(c), W'(b), W'(a)};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < LAT; k++) begin hv[k] = 1'b0; hd[k] = '0; ht[k] = "R8"; end
        // R8: reset state, while asserted with active-looking inputs
        repeat (3) @(negedge clk);
        in_valid = 1'b1; degrees = '1; ant_en = '1; norm_sel = 2'd2;
        repeat (2) @(negedge clk);
        check("R8 valid", int'(out_valid), 0);
        check("R8 strength", int'(strength), 0);
        in_valid = 1'b0; degrees = '0; ant_en = '0; norm_sel = 2'd0;
        rst = 1'b0;

        // Directed corners
        for (int s = 0; s < 4; s++) step('1, '1, 2'(s), 1'b1);              // full truth: R2 gives 252, R4 saturates
        for (int s = 0; s < 4; s++) step(pack4(9, 200, 77, 13), '0, 2'(s), 1'b1); // R6
        step(pack4(10, 0, 0, 0), 4'b0001, 2'd0, 1'b1);                      // R5: 10
        step(pack4(10, 0, 0, 0), 4'b0001, 2'd2, 1'b1);                      // R5: 255
        step(pack4(200, 3, 150, 90), 4'b1101, 2'd0, 1'b1);                  // R5: 90
        step(pack4(200, 3, 150, 90), 4'b1111, 2'd0, 1'b1);                  // R1: 3
        step(pack4(200, 3, 150, 90), 4'b1111, 2'd2, 1'b1);                  // R3: 200
        step(pack4(128, 128, 128, 128), 4'b1111, 2'd1, 1'b1);               // R2: 16
        step(pack4(100, 100, 0, 0), 4'b1111, 2'd3, 1'b1);                   // R4: 161
        step(pack4(1, 2, 3, 4), 4'b1111, 2'd1, 1'b0);                       // invalid beat, R7
        step(pack4(0, 255, 255, 255), 4'b1111, 2'd1, 1'b1);                 // R2: 0

        // Constrained random
        for (int n = 0; n < 600; n++) begin
            logic [N*W-1:0] dg;
            logic [N-1:0]   en;
            int r;
            for (int i = 0; i < N; i++) begin
                r = $urandom_range(0, 9);
                dg[i*W +: W] = (r == 0) ? '0 : (r == 1) ? '1 : W'($urandom);
            end
            r = $urandom_range(0, 9);
            en = (r < 4) ? '1 : (r == 4) ? '0 : N'($urandom);
            step(dg, en, 2'($urandom), ($urandom_range(0, 7) != 0));
        end

        for (int k = 0; k < LAT; k++) step('0, '0, 2'd0, 1'b0);
        @(negedge clk);
        check("R7 valid drain", int'(out_valid), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule